// File: doc/BRIEF.md
# Channel Program Executor Sequencer

This block is an I/O co-processor sequencer that runs a small program of command words held in shared memory. The host hands it a start request carrying the address of the first command word. After that the host takes no further part. The sequencer fetches each command word over a simple word memory bus and decodes it. It then moves bytes between a memory buffer and a byte-stream device port until the command's count is used up. If a command asks for chaining, the sequencer moves on to the command word that follows it.

When the program ends, normally or because a command word is malformed, the sequencer does two things in order. First it writes a two-word status record to a fixed memory location. Then it raises an interrupt that stays high until the host clears it. A start request that arrives while a program is running is turned away with a busy acknowledge, and the running program carries on unchanged.

Each command word is 64 bits and spans two memory words: the upper half at the command address and the lower half at the address plus 4. Data moves one byte per memory access, carried in bits 7:0 of the memory word.

Top module: `chanprog_exec`

## Requirements
- R1: After reset, `irq_o`, `mem_req_o`, `dev_tx_valid_o`, `dev_rx_ready_o`, `ack_started_o` and `ack_busy_o` are all low.
- R2: A start request in idle reads the upper command half at the start address, then the lower half at the start address plus 4. One cycle after the second read is acknowledged, `ack_started_o` pulses for one cycle. This happens once per program.
- R3: Command word layout: bits 63:56 are the opcode (0x01 memory-to-device, 0x02 device-to-memory, 0x03 no-op), bit 55 is the chain flag, bits 47:32 are the byte count and bits 31:0 are the buffer byte address.
- R4: Opcode 0x01 reads memory at buffer, buffer+1, … for count accesses and sends bits 7:0 of each word to the device port, in order.
- R5: Opcode 0x02 takes count bytes from the device port and writes each one to buffer, buffer+1, … as a word with the byte in bits 7:0 and zeros above.
- R6: When the chain flag is set, the next command word is fetched at the current command address plus 8. When it is clear, the program ends after the command.
- R7: A no-op moves no data and reports a residual count of 0.
- R8: An opcode other than 0x01–0x03 sets status bit 16, and a count of zero sets status bit 17. Either one ends the program at once without moving data, whatever the chain flag says, and the residual reported is the command's count.
- R9: At the end, the block writes the final command address to `STATUS_ADDR` and then `{14'b0, zero_count, bad_opcode, residual[15:0]}` to `STATUS_ADDR+4`. `irq_o` rises only in the cycle after that second write is acknowledged.
- R10: `irq_o` stays high until `irq_clr_i` is sampled high, and falls on the next cycle.
- R11: A start request while a program is running makes `ack_busy_o` pulse in the next cycle. The running program, its data and its status are not changed.
- R12: `mem_req_o` with its address and data is held until `mem_ack_i`. `dev_tx_valid_o` with its data is held until `dev_tx_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Host start request |
| start_addr_i | input | 32 | Address of first command word |
| ack_started_o | output | 1 | Pulse: program accepted and first command word read |
| ack_busy_o | output | 1 | Pulse: start refused, block busy |
| irq_o | output | 1 | Completion interrupt |
| irq_clr_i | input | 1 | Host interrupt clear |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory request completed |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| dev_tx_valid_o | output | 1 | Byte to device valid |
| dev_tx_data_o | output | 8 | Byte to device |
| dev_tx_ready_i | input | 1 | Device accepts byte |
| dev_rx_valid_i | input | 1 | Byte from device valid |
| dev_rx_data_i | input | 8 | Byte from device |
| dev_rx_ready_o | output | 1 | Block accepts byte from device |

## Verification
The hardest case to reach from the ports is a second start request that lands while a program is still moving data. The busy refusal has to show up without changing the final status or the byte stream. The stimulus stretches a memory-to-device command by throttling the device ready signal every other cycle. It then issues a second start with a different address in the middle of the transfer, and checks the busy pulse on the next cycle. Finally it checks that the status still names the first program and that every byte still arrives. Chaining is reached with a two-command program that mixes both directions, and the error paths come from table entries with a bad opcode or a zero count.

// File: rtl/chanprog_pkg.sv
package chanprog_pkg;
  localparam int AW      = 32;
  localparam int DW      = 32;
  localparam int CNT_W   = 16;
  localparam int BYTE_W  = 8;
  localparam int CCW_W   = 2 * DW;

  localparam logic [7:0] OP_TO_DEV  = 8'h01;
  localparam logic [7:0] OP_TO_MEM  = 8'h02;
  localparam logic [7:0] OP_NOP     = 8'h03;

  typedef enum logic [3:0] {
    S_IDLE, S_FHI, S_FLO, S_DEC, S_RDM, S_PUSH,
    S_PULL, S_WRM, S_NEXT, S_ST0, S_ST1
  } state_t;

  typedef struct packed {
    logic [7:0]       op;
    logic             chain;
    logic [CNT_W-1:0] count;
    logic [AW-1:0]    buf_addr;
    logic             bad_op;
    logic             zero_cnt;
  } ccw_t;
endpackage

// File: rtl/chanprog_decode.sv
module chanprog_decode
  import chanprog_pkg::*;
(
  input  logic [CCW_W-1:0] word_i,
  output ccw_t             ccw_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^word_i[54:48];

  always_comb begin
    ccw_o.op       = word_i[63:56];
    ccw_o.chain    = word_i[55];
    ccw_o.count    = word_i[47:32];
    ccw_o.buf_addr = word_i[31:0];
    ccw_o.bad_op   = !(ccw_o.op == OP_TO_DEV || ccw_o.op == OP_TO_MEM || ccw_o.op == OP_NOP);
    ccw_o.zero_cnt = (ccw_o.count == '0);
  end
endmodule

// File: rtl/chanprog_count.sv
module chanprog_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (load_i || dec_i) cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/chanprog_exec.sv
module chanprog_exec
  import chanprog_pkg::*;
#(
  parameter logic [31:0] STATUS_ADDR = 32'h0000_0040
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          ack_started_o,
  output logic          ack_busy_o,
  output logic          irq_o,
  input  logic          irq_clr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          dev_tx_valid_o,
  output logic [7:0]    dev_tx_data_o,
  input  logic          dev_tx_ready_i,
  input  logic          dev_rx_valid_i,
  input  logic [7:0]    dev_rx_data_i,
  output logic          dev_rx_ready_o
);
  localparam logic [AW-1:0] HALF_STEP = AW'(DW / 8);
  localparam logic [AW-1:0] CCW_STEP  = AW'(CCW_W / 8);
  localparam int            PAD_W     = DW - CNT_W - 2;

  state_t            state_q, state_d;
  logic [AW-1:0]     cmd_q, cmd_d, buf_q, buf_d;
  logic [DW-1:0]     hi_q, hi_d, lo_q, lo_d;
  logic              chain_q, chain_d, first_q, first_d;
  logic [1:0]        err_q, err_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              started_q, started_d, busy_q, busy_d, irq_q, irq_d;
  logic              cnt_load, cnt_dec, cnt_last;
  logic [CNT_W-1:0]  cnt_val, cnt;
  ccw_t              ccw;

  chanprog_decode u_dec (.word_i({hi_q, lo_q}), .ccw_o(ccw));

  chanprog_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(cnt_val),
    .dec_i(cnt_dec), .cnt_o(cnt), .last_o(cnt_last)
  );

  always_comb begin
    state_d = state_q;  cmd_d = cmd_q;  buf_d = buf_q;
    hi_d = hi_q;  lo_d = lo_q;  chain_d = chain_q;  first_d = first_q;
    err_d = err_q;  byte_d = byte_q;
    started_d = 1'b0;
    busy_d    = start_i && (state_q != S_IDLE);
    irq_d     = irq_q && !irq_clr_i;
    cnt_load = 1'b0;  cnt_val = '0;  cnt_dec = 1'b0;
    mem_req_o = 1'b0;  mem_we_o = 1'b0;  mem_addr_o = '0;  mem_wdata_o = '0;
    dev_tx_valid_o = 1'b0;  dev_rx_ready_o = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        cmd_d = start_addr_i;  first_d = 1'b1;  err_d = '0;  state_d = S_FHI;
      end
      S_FHI: begin
        mem_req_o = 1'b1;  mem_addr_o = cmd_q;
        if (mem_ack_i) begin hi_d = mem_rdata_i;  state_d = S_FLO; end
      end
      S_FLO: begin
        mem_req_o = 1'b1;  mem_addr_o = cmd_q + HALF_STEP;
        if (mem_ack_i) begin
          lo_d = mem_rdata_i;  started_d = first_q;  first_d = 1'b0;  state_d = S_DEC;
        end
      end
      S_DEC: begin
        chain_d = ccw.chain;  buf_d = ccw.buf_addr;  cnt_load = 1'b1;  cnt_val = ccw.count;
        if (ccw.bad_op || ccw.zero_cnt) begin
          err_d = {ccw.zero_cnt, ccw.bad_op};  state_d = S_ST0;
        end else if (ccw.op == OP_TO_DEV) state_d = S_RDM;
        else if (ccw.op == OP_TO_MEM)     state_d = S_PULL;
        else begin cnt_val = '0;  state_d = S_NEXT; end
      end
      S_RDM: begin
        mem_req_o = 1'b1;  mem_addr_o = buf_q;
        if (mem_ack_i) begin byte_d = mem_rdata_i[BYTE_W-1:0];  state_d = S_PUSH; end
      end
      S_PUSH: begin
        dev_tx_valid_o = 1'b1;
        if (dev_tx_ready_i) begin
          cnt_dec = 1'b1;  buf_d = buf_q + AW'(1);
          state_d = cnt_last ? S_NEXT : S_RDM;
        end
      end
      S_PULL: begin
        dev_rx_ready_o = 1'b1;
        if (dev_rx_valid_i) begin byte_d = dev_rx_data_i;  state_d = S_WRM; end
      end
      S_WRM: begin
        mem_req_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = buf_q;
        mem_wdata_o = {{(DW-BYTE_W){1'b0}}, byte_q};
        if (mem_ack_i) begin
          cnt_dec = 1'b1;  buf_d = buf_q + AW'(1);
          state_d = cnt_last ? S_NEXT : S_PULL;
        end
      end
      S_NEXT: begin
        if (chain_q) begin cmd_d = cmd_q + CCW_STEP;  state_d = S_FHI; end
        else state_d = S_ST0;
      end
      S_ST0: begin
        mem_req_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = STATUS_ADDR;  mem_wdata_o = cmd_q;
        if (mem_ack_i) state_d = S_ST1;
      end
      S_ST1: begin
        mem_req_o = 1'b1;  mem_we_o = 1'b1;  mem_addr_o = STATUS_ADDR + HALF_STEP;
        mem_wdata_o = {{PAD_W{1'b0}}, err_q, cnt};
        if (mem_ack_i) begin irq_d = 1'b1;  state_d = S_IDLE; end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  cmd_q <= '0;  buf_q <= '0;  hi_q <= '0;  lo_q <= '0;
      chain_q <= 1'b0;  first_q <= 1'b0;  err_q <= '0;  byte_q <= '0;
      started_q <= 1'b0;  busy_q <= 1'b0;  irq_q <= 1'b0;
    end else begin
      state_q <= state_d;  cmd_q <= cmd_d;  buf_q <= buf_d;  hi_q <= hi_d;  lo_q <= lo_d;
      chain_q <= chain_d;  first_q <= first_d;  err_q <= err_d;  byte_q <= byte_d;
      started_q <= started_d;  busy_q <= busy_d;  irq_q <= irq_d;
    end
  end

  assign ack_started_o = started_q;
  assign ack_busy_o    = busy_q;
  assign irq_o         = irq_q;
  assign dev_tx_data_o = byte_q;
endmodule

// File: rtl/chanprog_exec_chk.sv
module chanprog_exec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        ack_busy_o,
  input logic        irq_o,
  input logic        irq_clr_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic        mem_ack_i,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        dev_tx_valid_o,
  input logic        dev_tx_ready_i,
  input logic [7:0]  dev_tx_data_o,
  input logic        dev_rx_ready_o
);
  AST_IRQ_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R9
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_clr_i) |=> irq_o); // R10
  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && irq_clr_i) |=> !irq_o); // R10
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    ack_busy_o |-> $past(start_i)); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)
                                   && $stable(mem_wdata_o) && $stable(mem_we_o))); // R12
  AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_tx_valid_o && !dev_tx_ready_i) |=> (dev_tx_valid_o && $stable(dev_tx_data_o))); // R12
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_req_o, dev_tx_valid_o, dev_rx_ready_o})); // R12
endmodule

bind chanprog_exec chanprog_exec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_busy_o(ack_busy_o),
  .irq_o(irq_o), .irq_clr_i(irq_clr_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
  .dev_tx_valid_o(dev_tx_valid_o), .dev_tx_ready_i(dev_tx_ready_i),
  .dev_tx_data_o(dev_tx_data_o), .dev_rx_ready_o(dev_rx_ready_o)
);

// File: tb/chanprog_exec_tb.sv
`timescale 1ns/1ps
module chanprog_exec_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] start_addr = '0;
  logic irq_clr = 1'b0;
  logic ack_started, ack_busy, irq;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic stall_en = 1'b0;
  logic [3:0] cyc;

  logic [31:0] mem [0:1023];
  logic [7:0]  txlog [0:255];
  logic [7:0]  rxbuf [0:255];
  int txn, rxi, rxn, n_started, n_busy;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  chanprog_exec u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .start_addr_i(start_addr),
    .ack_started_o(ack_started), .ack_busy_o(ack_busy), .irq_o(irq), .irq_clr_i(irq_clr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .dev_tx_valid_o(tx_valid), .dev_tx_data_o(tx_data), .dev_tx_ready_i(tx_ready),
    .dev_rx_valid_i(rx_valid), .dev_rx_data_i(rx_data), .dev_rx_ready_o(rx_ready)
  );

  // memory model: ack one cycle after request, every other cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin mem_ack <= 1'b0; mem_rdata <= '0; end
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        mem_rdata <= mem[mem_addr[9:0]];
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin cyc <= '0; txn <= 0; rxi <= 0; n_started <= 0; n_busy <= 0; end
    else begin
      cyc <= cyc + 4'd1;
      if (tx_valid && tx_ready) begin txlog[txn[7:0]] <= tx_data; txn <= txn + 1; end
      if (rx_valid && rx_ready) rxi <= rxi + 1;
      if (ack_started) n_started <= n_started + 1;
      if (ack_busy) n_busy <= n_busy + 1;
    end
  end
  assign tx_ready = !stall_en || cyc[0];
  assign rx_valid = (rxi < rxn);
  assign rx_data  = rxbuf[rxi[7:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic kick(input logic [31:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_irq(input string tag);
    int k;
    k = 0;
    while (!irq && k < 3000) begin @(negedge clk); k++; end
    chk(tag, {31'd0, irq}, 32'd1);
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  // {opcode, count, expected second status word}
  localparam logic [55:0] VEC [7] = '{
    {8'h01, 16'd3, 32'h0000_0000},
    {8'h02, 16'd4, 32'h0000_0000},
    {8'h03, 16'd5, 32'h0000_0000},
    {8'h07, 16'd2, 32'h0001_0002},
    {8'h01, 16'd0, 32'h0002_0000},
    {8'h00, 16'd0, 32'h0003_0000},
    {8'h02, 16'd1, 32'h0000_0000}
  };

  initial begin
    repeat (1000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rxn = 0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD_0000 | 32'(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 outputs", {28'd0, mem_req, tx_valid, rx_ready, ack_started | ack_busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {29'd0, mem_req, tx_valid, rx_ready}, 32'd0);

    // table of single-command programs
    for (int i = 0; i < 7; i++) begin
      logic [7:0] op; logic [15:0] cnt; logic [31:0] exp1;
      int t0, s0;
      {op, cnt, exp1} = VEC[i];
      mem[10'h040] = 32'hFFFF_FFFF; mem[10'h044] = 32'hFFFF_FFFF;
      mem[10'h100] = {op, 8'h00, cnt};          // R3 layout, chain clear
      mem[10'h104] = 32'h0000_0200;
      for (int j = 0; j < 16; j++) begin
        mem[10'h200 + 10'(j)] = 32'hCAFE_0000 | 32'(8'hA0 + 8'(j));
        rxbuf[8'(rxi + j)] = 8'h50 + 8'(j) + 8'(i);
      end
      rxn = rxi + ((op == 8'h02) ? int'(cnt) : 0);
      t0 = txn; s0 = n_started;
      kick(32'h0000_0100);
      wait_irq("R9 irq raised");
      chk("R9 status word0 cmd addr", mem[10'h040], 32'h0000_0100);
      chk("R8 R9 status word1", mem[10'h044], exp1);
      chk("R2 one started ack", 32'(n_started - s0), 32'd1);
      if (op == 8'h01 && cnt != 0) begin
        chk("R4 tx count", 32'(txn - t0), 32'(cnt));
        for (int j = 0; j < int'(cnt); j++)
          chk("R4 tx byte", {24'd0, txlog[8'(t0 + j)]}, 32'(8'hA0 + 8'(j)));
      end else chk("R7 R8 no tx data", 32'(txn - t0), 32'd0);
      if (op == 8'h02) begin
        for (int j = 0; j < int'(cnt); j++)
          chk("R5 rx byte in memory", mem[10'h200 + 10'(j)], 32'(8'h50 + 8'(j) + 8'(i)));
        chk("R5 byte past end untouched", mem[10'h200 + 10'(cnt)], 32'hCAFE_0000 | 32'(8'hA0 + 8'(cnt)));
      end
      @(negedge clk); @(negedge clk);
      chk("R10 irq held", {31'd0, irq}, 32'd1);
      clear_irq();
      chk("R10 irq cleared", {31'd0, irq}, 32'd0);
    end

    // R6 chain: write 2 bytes then read 3 bytes
    begin
      int t0, s0;
      mem[10'h120] = {8'h01, 8'h80, 16'd2}; mem[10'h124] = 32'h0000_0210;
      mem[10'h128] = {8'h02, 8'h00, 16'd3}; mem[10'h12C] = 32'h0000_0300;
      mem[10'h210] = 32'h0000_0011; mem[10'h211] = 32'h0000_0022;
      for (int j = 0; j < 3; j++) rxbuf[8'(rxi + j)] = 8'hC0 + 8'(j);
      rxn = rxi + 3;
      t0 = txn; s0 = n_started;
      kick(32'h0000_0120);
      wait_irq("R6 chain irq");
      chk("R6 final cmd addr is +8", mem[10'h040], 32'h0000_0128);
      chk("R6 residual zero", mem[10'h044], 32'd0);
      chk("R6 first command bytes", 32'(txn - t0), 32'd2);
      chk("R6 first byte", {24'd0, txlog[8'(t0)]}, 32'h11);
      chk("R6 second command data", mem[10'h302], 32'h0000_00C2);
      chk("R2 single ack for chain", 32'(n_started - s0), 32'd1);
      clear_irq();
    end

    // R11 start while busy, with throttled device (R12)
    begin
      int t0, b0;
      stall_en = 1'b1;
      mem[10'h140] = {8'h01, 8'h00, 16'd6}; mem[10'h144] = 32'h0000_0200;
      mem[10'h180] = {8'h03, 8'h00, 16'd1}; mem[10'h184] = 32'h0;
      t0 = txn; b0 = n_busy;
      kick(32'h0000_0140);
      repeat (12) @(negedge clk);
      start = 1'b1; start_addr = 32'h0000_0180;
      @(negedge clk); start = 1'b0;
      chk("R11 busy ack next cycle", {31'd0, ack_busy}, 32'd1);
      @(negedge clk);
      chk("R11 busy ack one cycle", {31'd0, ack_busy}, 32'd0);
      wait_irq("R11 irq");
      chk("R11 status names first program", mem[10'h040], 32'h0000_0140);
      chk("R11 R12 all bytes delivered", 32'(txn - t0), 32'd6);
      chk("R12 last byte under stall", {24'd0, txlog[8'(t0 + 5)]}, 32'hA5);
      chk("R11 busy count", 32'(n_busy - b0), 32'd1);
      stall_en = 1'b0;
      clear_irq();
    end

    summary();
    $finish;
  end
endmodule